// File: doc/BRIEF.md
# Stack Machine Dual-Path Memory Port

This block is the memory-facing side of a microprogrammed stack machine. It holds four datapath-visible registers: a word address register, a word data register, a program byte pointer and an instruction byte buffer. It serves two independent access paths into one small synchronous store. The word path treats its address register as a count of 32-bit words and supports reads and writes. The instruction path treats the program pointer as a count of bytes and fetches one byte per request.

Every request is a one-cycle strobe that the block samples at a clock edge. The result lands in its target register one full cycle later. In the cycle between, the target register keeps its old contents unless the datapath loads it. When memory data and a datapath load arrive at the same edge, the memory data wins. The byte buffer is offered to the datapath both sign-extended and zero-extended to 32 bits. A word read and a byte fetch may be in flight together. Asking for a word read and a word write in the same cycle is illegal: the block flags it and drops both.

Top module: `smx_mem_port`

## Requirements
- R1: After a synchronous reset, all four registers read zero, every store word reads zero, `rw_clash` is low, and both presented addresses are zero.
- R2: With no memory result arriving, a load strobe (`mar_we`, `mdr_we`, `pc_we`, `mbr_we`) copies its input into the matching register at the clock edge where it is sampled.
- R3: A word request sampled at edge N presents byte address {MAR[29:0],2'b00} on `data_baddr` from edge N onward. The store word index is `data_baddr[2 +: log2(MEM_WORDS)]`, so word addresses wrap modulo `MEM_WORDS`.
- R4: A word read sampled at edge N puts the addressed store word into MDR at edge N+1. MDR is unchanged at edge N unless `mdr_we` was asserted there.
- R5: A word write sampled at edge N stores the MDR value present before edge N into the addressed word at edge N+1. A read sampled at edge N+1 or later returns that value.
- R6: A fetch sampled at edge N puts the byte at program address PC into MBR at edge N+1. Byte address 4w+k selects bits [8k+7:8k] of store word w (little-endian lanes). MBR is unchanged at edge N unless `mbr_we` was asserted there.
- R7: `mbr_u` is MBR zero-extended to 32 bits, and `mbr_s` is MBR sign-extended from bit 7.
- R8: When returning memory data and a datapath load of the same register (MDR or MBR) coincide at one edge, the register takes the memory data.
- R9: A word read and a byte fetch sampled at the same edge both complete at the next edge with their own correct data.
- R10: `rd_req` and `wr_req` high together raise `rw_clash` in that cycle. Both requests are discarded: MDR receives no memory data and the store is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mar_we | input | 1 | Load word address register |
| mar_din | input | 32 | Word address to load |
| mdr_we | input | 1 | Load word data register from datapath |
| mdr_din | input | 32 | Datapath value for word data register |
| pc_we | input | 1 | Load program byte pointer |
| pc_din | input | 32 | Byte address to load |
| mbr_we | input | 1 | Load instruction byte buffer from datapath |
| mbr_din | input | 8 | Datapath value for byte buffer |
| rd_req | input | 1 | Word read strobe |
| wr_req | input | 1 | Word write strobe |
| fetch_req | input | 1 | Instruction byte fetch strobe |
| mar_q | output | 32 | Word address register |
| mdr_q | output | 32 | Word data register |
| pc_q | output | 32 | Program byte pointer |
| mbr_s | output | 32 | Byte buffer, sign-extended |
| mbr_u | output | 32 | Byte buffer, zero-extended |
| data_baddr | output | 32 | Byte address of the latest word request |
| fetch_baddr | output | 32 | Byte address of the latest fetch |
| rw_clash | output | 1 | Read and write requested together |

## Verification
The bench writes every word of the store and reads each one back. On every read it checks the gap cycle and the presented byte address. A design that let the register move early, or that skipped the shift by two, would show a wrong MDR one cycle too soon or a wrong address. It then fetches all byte addresses and compares both extensions. A swapped lane order or a zero-fill in place of sign extension would show up on the bytes with bit 7 set. Directed cases cover the remaining orderings: a datapath load colliding with arriving data (a wrong priority leaves the datapath value), a write followed at once by a read (a stale read returns old data), a concurrent read and fetch, an address past the store depth, and a read/write clash, which must leave both MDR and the store untouched.

// File: rtl/smx_mem_pkg.sv
package smx_mem_pkg;
    localparam int WORD_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int LANES     = WORD_W / BYTE_W;
    localparam int LANE_BITS = $clog2(LANES);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        WOP_NONE  = 2'd0,
        WOP_READ  = 2'd1,
        WOP_WRITE = 2'd2
    } wop_e;

    typedef struct packed {
        wop_e  op;
        word_t baddr;
        word_t wdata;
    } wreq_t;

    typedef struct packed {
        logic  vld;
        word_t baddr;
    } breq_t;

    function automatic word_t word_to_baddr(word_t w);
        return w << LANE_BITS;
    endfunction

    function automatic word_t sext_byte(byte_t b);
        return {{(WORD_W-BYTE_W){b[BYTE_W-1]}}, b};
    endfunction

    function automatic word_t zext_byte(byte_t b);
        return {{(WORD_W-BYTE_W){1'b0}}, b};
    endfunction

    function automatic byte_t pick_lane(word_t w, logic [LANE_BITS-1:0] sel);
        word_t shifted;
        shifted = w >> (int'(sel) * BYTE_W);
        return shifted[BYTE_W-1:0];
    endfunction
endpackage

// File: rtl/smx_store.sv
module smx_store
    import smx_mem_pkg::*;
#(
    parameter int WORDS = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          w_we,
    input  logic [$clog2(WORDS)-1:0]      w_idx,
    input  word_t                         w_wdata,
    input  logic [$clog2(WORDS)-1:0]      b_idx,
    input  logic [LANE_BITS-1:0]          b_lane,
    output word_t                         rd_word,
    output byte_t                         rd_byte
);
    word_t mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (w_we) begin
            mem[w_idx] <= w_wdata;
        end
    end

    always_comb begin
        rd_word = mem[w_idx];
        rd_byte = pick_lane(mem[b_idx], b_lane);
    end
endmodule

// File: rtl/smx_word_path.sv
module smx_word_path
    import smx_mem_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  mar_we,
    input  word_t mar_din,
    input  logic  mdr_we,
    input  word_t mdr_din,
    input  logic  rd_req,
    input  logic  wr_req,
    input  word_t mem_word,
    output word_t mar_q,
    output word_t mdr_q,
    output wreq_t req_q,
    output logic  rw_clash
);
    wop_e next_op;

    always_comb begin
        rw_clash = rd_req & wr_req;
        if (rw_clash)    next_op = WOP_NONE;
        else if (rd_req) next_op = WOP_READ;
        else if (wr_req) next_op = WOP_WRITE;
        else             next_op = WOP_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mar_q <= '0;
            mdr_q <= '0;
            req_q <= '{op: WOP_NONE, baddr: '0, wdata: '0};
        end else begin
            if (mar_we) mar_q <= mar_din;
            // arriving read data takes priority over a datapath load
            if (req_q.op == WOP_READ) mdr_q <= mem_word;
            else if (mdr_we)          mdr_q <= mdr_din;
            req_q.op <= next_op;
            if (next_op != WOP_NONE) begin
                req_q.baddr <= word_to_baddr(mar_q);
                req_q.wdata <= mdr_q;
            end
        end
    end

    // R4: MDR holds through the edge that samples a read
    a_r4_mdr_gap_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !wr_req && !mdr_we && req_q.op != WOP_READ) |=> $stable(mdr_q));

    // R8: the store word wins over any coincident datapath load
    a_r8_read_wins: assert property (@(posedge clk) disable iff (rst)
        (req_q.op == WOP_READ) |=> (mdr_q == $past(mem_word)));

    // R10: clashing strobes leave no request behind
    a_r10_clash_drops: assert property (@(posedge clk) disable iff (rst)
        (rd_req && wr_req) |=> (req_q.op == WOP_NONE));
endmodule

// File: rtl/smx_byte_path.sv
module smx_byte_path
    import smx_mem_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pc_we,
    input  word_t pc_din,
    input  logic  mbr_we,
    input  byte_t mbr_din,
    input  logic  fetch_req,
    input  byte_t mem_byte,
    output word_t pc_q,
    output byte_t mbr_q,
    output breq_t req_q,
    output word_t mbr_s,
    output word_t mbr_u
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            mbr_q <= '0;
            req_q <= '{vld: 1'b0, baddr: '0};
        end else begin
            if (pc_we) pc_q <= pc_din;
            // an arriving fetch byte takes priority over a datapath load
            if (req_q.vld)   mbr_q <= mem_byte;
            else if (mbr_we) mbr_q <= mbr_din;
            req_q.vld <= fetch_req;
            if (fetch_req) req_q.baddr <= pc_q;
        end
    end

    always_comb begin
        mbr_s = sext_byte(mbr_q);
        mbr_u = zext_byte(mbr_q);
    end

    // R6: MBR holds through the edge that samples a fetch
    a_r6_mbr_gap_hold: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !mbr_we && !req_q.vld) |=> $stable(mbr_q));

    // R8: the fetched byte wins over any coincident datapath load
    a_r8_fetch_wins: assert property (@(posedge clk) disable iff (rst)
        req_q.vld |=> (mbr_q == $past(mem_byte)));
endmodule

// File: rtl/smx_mem_port.sv
module smx_mem_port
    import smx_mem_pkg::*;
#(
    parameter int MEM_WORDS = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mar_we,
    input  logic [WORD_W-1:0]   mar_din,
    input  logic                mdr_we,
    input  logic [WORD_W-1:0]   mdr_din,
    input  logic                pc_we,
    input  logic [WORD_W-1:0]   pc_din,
    input  logic                mbr_we,
    input  logic [BYTE_W-1:0]   mbr_din,
    input  logic                rd_req,
    input  logic                wr_req,
    input  logic                fetch_req,
    output logic [WORD_W-1:0]   mar_q,
    output logic [WORD_W-1:0]   mdr_q,
    output logic [WORD_W-1:0]   pc_q,
    output logic [WORD_W-1:0]   mbr_s,
    output logic [WORD_W-1:0]   mbr_u,
    output logic [WORD_W-1:0]   data_baddr,
    output logic [WORD_W-1:0]   fetch_baddr,
    output logic                rw_clash
);
    localparam int IDX_W = $clog2(MEM_WORDS);

    wreq_t wreq;
    breq_t breq;
    word_t mem_word;
    byte_t mem_byte;
    byte_t mbr_raw;

    smx_word_path u_word (
        .clk      (clk),
        .rst      (rst),
        .mar_we   (mar_we),
        .mar_din  (mar_din),
        .mdr_we   (mdr_we),
        .mdr_din  (mdr_din),
        .rd_req   (rd_req),
        .wr_req   (wr_req),
        .mem_word (mem_word),
        .mar_q    (mar_q),
        .mdr_q    (mdr_q),
        .req_q    (wreq),
        .rw_clash (rw_clash)
    );

    smx_byte_path u_byte (
        .clk       (clk),
        .rst       (rst),
        .pc_we     (pc_we),
        .pc_din    (pc_din),
        .mbr_we    (mbr_we),
        .mbr_din   (mbr_din),
        .fetch_req (fetch_req),
        .mem_byte  (mem_byte),
        .pc_q      (pc_q),
        .mbr_q     (mbr_raw),
        .req_q     (breq),
        .mbr_s     (mbr_s),
        .mbr_u     (mbr_u)
    );

    smx_store #(.WORDS(MEM_WORDS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .w_we    (wreq.op == WOP_WRITE),
        .w_idx   (wreq.baddr[LANE_BITS +: IDX_W]),
        .w_wdata (wreq.wdata),
        .b_idx   (breq.baddr[LANE_BITS +: IDX_W]),
        .b_lane  (breq.baddr[LANE_BITS-1:0]),
        .rd_word (mem_word),
        .rd_byte (mem_byte)
    );

    assign data_baddr  = wreq.baddr;
    assign fetch_baddr = breq.baddr;

    // R3: presented word-port addresses are always word aligned
    a_r3_aligned: assert property (@(posedge clk) disable iff (rst)
        (wreq.op != WOP_NONE) |-> (data_baddr[LANE_BITS-1:0] == '0));
endmodule

// File: tb/smx_mem_port_tb.sv
`timescale 1ns/1ps
module smx_mem_port_tb;
    localparam int NW = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mar_we = 0, mdr_we = 0, pc_we = 0, mbr_we = 0;
    logic [31:0] mar_din = 0, mdr_din = 0, pc_din = 0;
    logic [7:0]  mbr_din = 0;
    logic        rd_req = 0, wr_req = 0, fetch_req = 0;
    logic [31:0] mar_q, mdr_q, pc_q, mbr_s, mbr_u, data_baddr, fetch_baddr;
    logic        rw_clash;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] exp_mem [NW];

    always #2.5 clk = ~clk;

    smx_mem_port #(.MEM_WORDS(NW)) u_dut (
        .clk(clk), .rst(rst),
        .mar_we(mar_we), .mar_din(mar_din),
        .mdr_we(mdr_we), .mdr_din(mdr_din),
        .pc_we(pc_we), .pc_din(pc_din),
        .mbr_we(mbr_we), .mbr_din(mbr_din),
        .rd_req(rd_req), .wr_req(wr_req), .fetch_req(fetch_req),
        .mar_q(mar_q), .mdr_q(mdr_q), .pc_q(pc_q),
        .mbr_s(mbr_s), .mbr_u(mbr_u),
        .data_baddr(data_baddr), .fetch_baddr(fetch_baddr),
        .rw_clash(rw_clash)
    );

    function automatic logic [31:0] pat(int i);
        return (32'(i) + 32'd1) * 32'h9E37_79B9;
    endfunction

    function automatic logic [7:0] exp_byte(int b);
        logic [31:0] w;
        w = exp_mem[(b / 4) % NW];
        return 8'(w >> (8 * (b % 4)));
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(int w, logic [31:0] d);
        mar_we = 1; mar_din = 32'(w); mdr_we = 1; mdr_din = d;
        step();
        mar_we = 0; mdr_we = 0; wr_req = 1;
        step();
        wr_req = 0;
        step();
        exp_mem[w % NW] = d;
    endtask

    task automatic do_read(int w);
        logic [31:0] prev;
        mar_we = 1; mar_din = 32'(w);
        step();
        mar_we = 0; prev = mdr_q; rd_req = 1;
        step();
        rd_req = 0;
        check("R3 word byte address", data_baddr, 32'(w) << 2);
        check("R4 MDR holds in gap", mdr_q, prev);
        step();
        check("R4/R5 read data", mdr_q, exp_mem[w % NW]);
    endtask

    task automatic do_fetch(int b);
        logic [31:0] prev;
        logic [7:0]  e;
        pc_we = 1; pc_din = 32'(b);
        step();
        pc_we = 0; prev = mbr_u; fetch_req = 1;
        step();
        fetch_req = 0;
        check("R6 MBR holds in gap", mbr_u, prev);
        step();
        e = exp_byte(b);
        check("R6/R7 zero-extended byte", mbr_u, {24'h0, e});
        check("R7 sign-extended byte", mbr_s, {{24{e[7]}}, e});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) exp_mem[i] = 32'h0;
        #1;
        step(); step();
        rst = 0;
        // R1 reset state
        check("R1 MAR reset", mar_q, 0);
        check("R1 MDR reset", mdr_q, 0);
        check("R1 PC reset", pc_q, 0);
        check("R1 MBR reset", mbr_u, 0);
        check("R1 addr reset", data_baddr | fetch_baddr, 0);
        check("R1 clash reset", {31'h0, rw_clash}, 0);
        do_read(5);
        do_fetch(22);

        // R2 datapath loads
        mar_we = 1; mar_din = 32'hA1B2_C3D4; mdr_we = 1; mdr_din = 32'h0BAD_F00D;
        pc_we = 1; pc_din = 32'h0000_1234; mbr_we = 1; mbr_din = 8'hC7;
        step();
        mar_we = 0; mdr_we = 0; pc_we = 0; mbr_we = 0;
        check("R2 MAR load", mar_q, 32'hA1B2_C3D4);
        check("R2 MDR load", mdr_q, 32'h0BAD_F00D);
        check("R2 PC load", pc_q, 32'h0000_1234);
        check("R2 MBR load", mbr_s, 32'hFFFF_FFC7);

        // sweep: fill then read back every word
        for (int i = 0; i < NW; i++) do_write(i, pat(i));
        for (int i = 0; i < NW; i++) do_read(i);
        // sweep: every byte address
        for (int b = 0; b < 4 * NW; b++) do_fetch(b);

        // R3 wrap past store depth
        do_read(NW + 3);

        // R8 arriving data beats datapath load in gap cycle
        mar_we = 1; mar_din = 12; pc_we = 1; pc_din = 32'h31;
        step();
        mar_we = 0; pc_we = 0; rd_req = 1; fetch_req = 1;
        step();
        rd_req = 0; fetch_req = 0;
        mdr_we = 1; mdr_din = 32'hDEAD_BEEF; mbr_we = 1; mbr_din = 8'h5A;
        step();
        mdr_we = 0; mbr_we = 0;
        check("R8 MDR takes memory word", mdr_q, exp_mem[12]);
        check("R8 MBR takes memory byte", mbr_u, {24'h0, exp_byte(32'h31)});

        // R8 datapath load in the request cycle, then overwritten
        mdr_we = 1; mdr_din = 32'h1111_2222; rd_req = 1;
        step();
        mdr_we = 0; rd_req = 0;
        check("R8 MDR datapath value in gap", mdr_q, 32'h1111_2222);
        step();
        check("R8 MDR overwritten by read", mdr_q, exp_mem[12]);

        // R9 concurrent read and fetch
        mar_we = 1; mar_din = 20; pc_we = 1; pc_din = 4 * 33 + 2;
        step();
        mar_we = 0; pc_we = 0; rd_req = 1; fetch_req = 1;
        step();
        rd_req = 0; fetch_req = 0;
        step();
        check("R9 concurrent read", mdr_q, exp_mem[20]);
        check("R9 concurrent fetch", mbr_u, {24'h0, exp_byte(4 * 33 + 2)});
        check("R9 fetch address", fetch_baddr, 4 * 33 + 2);

        // R5 write followed at once by read
        mar_we = 1; mar_din = 7; mdr_we = 1; mdr_din = 32'h1234_5678;
        step();
        mar_we = 0; mdr_we = 0; wr_req = 1;
        step();
        wr_req = 0; rd_req = 1;
        mdr_we = 1; mdr_din = 32'h0;
        step();
        rd_req = 0; mdr_we = 0;
        step();
        exp_mem[7] = 32'h1234_5678;
        check("R5 back-to-back write/read", mdr_q, 32'h1234_5678);
        do_fetch(4 * 7 + 3);

        // R10 read/write clash
        mar_we = 1; mar_din = 9; mdr_we = 1; mdr_din = 32'hCAFE_F00D;
        step();
        mar_we = 0; mdr_we = 0; rd_req = 1; wr_req = 1;
        #1;
        check("R10 clash flagged", {31'h0, rw_clash}, 1);
        step();
        rd_req = 0; wr_req = 0;
        #1;
        check("R10 clash clears", {31'h0, rw_clash}, 0);
        step();
        check("R10 no read delivered", mdr_q, 32'hCAFE_F00D);
        do_read(9);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule